// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a parameterised number of asynchronous interrupt pins from outside the chip and turns them into one combined interrupt request and one non-maskable request for the processor. Each pin passes through a two-stage synchroniser. A per-line sensing unit then raises a sticky pending bit. The unit senses either an edge (rising or falling) or a level (high or low), and the choice is made through three independent bit planes.

Software reaches the block over a plain 32-bit word bus. Reads are combinational and writes take effect on the clock edge. The enable mask is changed only through separate set and clear words, and pending bits are cleared through an acknowledge word. Only the implemented lines hold state. Software can therefore find the line count by writing all ones to the sense-select word and reading it back. Line 0 can also drive the non-maskable output, and that path ignores the mask.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the mask, pending, sense-select, edge-polarity, level-polarity and NMI-control words read zero, and `irq_o` and `nmi_o` are low.
- R2: Writing to offset 0x00 sets every mask bit whose data bit is 1, and writing to offset 0x04 clears every mask bit whose data bit is 1. Zero data bits leave the mask unchanged. The mask reads back at offset 0x08.
- R3: A line in edge mode (its bit at offset 0x14 is 0) detects a rising edge when its bit at 0x18 is 1 and a falling edge when that bit is 0. The pending bit (offset 0x0C) is set no later than the third clock edge after the pin changes, and it stays set while the pin holds still.
- R4: Writing to offset 0x10 clears the pending bits whose data bit is 1. Bits written as 0 keep their pending state.
- R5: A line in level mode (bit at 0x14 is 1) is active high when its bit at 0x1C is 1 and active low when that bit is 0. The line's pending bit is set on every cycle the synchronised pin is active, so an acknowledge has no lasting effect until the pin goes inactive.
- R6: `irq_o` is high exactly when some line is both pending and enabled in the mask.
- R7: `nmi_o` equals the pending bit of line 0 while bit 0 at offset 0x24 is 1, whatever the mask holds. It is low while that bit is 0.
- R8: Bits for lines at or above NUM_LINES are not stored and read as zero. Writing all ones to 0x14 reads back as (1 << NUM_LINES) - 1.
- R9: Reads of offsets with no register (including 0x00, 0x04, 0x10 and 0x20) return zero. Writes to the read-only offsets 0x08 and 0x0C change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Combined maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request from line 0 |

## Verification
The sensing logic is driven with a rising pin on a line set for rising edges and with a rise-then-fall on a line set for falling edges. This shows that each polarity catches only its own transition, and that a pin held high after acknowledge does not set the bit again. A level-high line is held active through an acknowledge and then released. This separates a pending bit that is set on every cycle from a sticky edge latch. The combined and non-maskable outputs are checked with the mask both set and clear, which shows that only the maskable path depends on it. An all-ones write to the sense plane checks that line discovery returns exactly the implemented lines.

// File: rtl/xint_pkg.sv
// Shared constants for the external interrupt line controller.
// Assumes a byte-addressed bus carrying 32-bit words.
package xint_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // Word offsets decoded by software drivers
    localparam logic [ADDR_W-1:0] OFS_MASK_SET  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK      = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PEND      = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ACK       = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SENSE_SEL = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EDGE_POL  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LVL_POL   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_NMI_CTRL  = 8'h24;
endpackage

// File: rtl/xint_sync.sv
// Two-stage synchroniser for a vector of asynchronous pins.
// Assumes every bit is independent; no bus coherency is needed.
module xint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Capture the pins, then retime once more to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/xint_line.sv
// Sensing unit and sticky pending bit for one interrupt line.
// Assumes sync_in is already synchronous. In level mode a set on the
// same cycle as an acknowledge takes priority over the acknowledge.
module xint_line (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic sense_lvl,   // 1 = level, 0 = edge
    input  logic edge_rise,   // 1 = rising, 0 = falling
    input  logic lvl_high,    // 1 = active high, 0 = active low
    input  logic ack,
    output logic pending
);
    logic prev_q;
    logic hit;

    // Decide whether the current sample is a triggering event
    always_comb begin
        if (sense_lvl)
            hit = (sync_in == lvl_high);
        else if (edge_rise)
            hit = sync_in & ~prev_q;
        else
            hit = ~sync_in & prev_q;
    end

    // Keep the previous sample and update the sticky pending bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            prev_q  <= sync_in;
            pending <= hit | (pending & ~ack);
        end
    end
endmodule

// File: rtl/xint_regs.sv
// Register file for the controller: mask, sense planes, NMI control
// and the read mux. Assumes one access per cycle; only the low
// NUM_LINES data bits are stored, the rest read as zero.
module xint_regs
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pending,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] sense_lvl,
    output logic [NUM_LINES-1:0] edge_rise,
    output logic [NUM_LINES-1:0] lvl_high,
    output logic [NUM_LINES-1:0] ack,
    output logic                 nmi_en
);
    logic                 wr;
    logic [NUM_LINES-1:0] wbits;

    assign wr    = bus_valid & bus_write;
    assign wbits = bus_wdata[NUM_LINES-1:0];

    // Acknowledge is a one-cycle strobe towards the line units
    assign ack = (wr && bus_addr == OFS_ACK) ? wbits : '0;

    // Update the writable registers from decoded writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '0;
            sense_lvl <= '0;
            edge_rise <= '0;
            lvl_high  <= '0;
            nmi_en    <= 1'b0;
        end else if (wr) begin
            case (bus_addr)
                OFS_MASK_SET:  mask      <= mask | wbits;
                OFS_MASK_CLR:  mask      <= mask & ~wbits;
                OFS_SENSE_SEL: sense_lvl <= wbits;
                OFS_EDGE_POL:  edge_rise <= wbits;
                OFS_LVL_POL:   lvl_high  <= wbits;
                OFS_NMI_CTRL:  nmi_en    <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Combinational read mux, zero-extended to the word width
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (bus_addr)
                OFS_MASK:      bus_rdata = DATA_W'(mask);
                OFS_PEND:      bus_rdata = DATA_W'(pending);
                OFS_SENSE_SEL: bus_rdata = DATA_W'(sense_lvl);
                OFS_EDGE_POL:  bus_rdata = DATA_W'(edge_rise);
                OFS_LVL_POL:   bus_rdata = DATA_W'(lvl_high);
                OFS_NMI_CTRL:  bus_rdata = DATA_W'(nmi_en);
                default:       bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/xint_ctrl.sv
// Top of the external interrupt line controller. Synchronises the pins,
// runs one sensing unit per line and forms the combined and
// non-maskable requests. Assumes 1 <= NUM_LINES <= 32.
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_pin,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o,
    output logic                 nmi_o
);
    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] sense_q;
    logic [NUM_LINES-1:0] epol_q;
    logic [NUM_LINES-1:0] lpol_q;
    logic [NUM_LINES-1:0] ack_s;
    logic                 nmi_en_q;

    xint_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_pin),
        .sync_out (pin_sync)
    );

    xint_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pending   (pend_q),
        .mask      (mask_q),
        .sense_lvl (sense_q),
        .edge_rise (epol_q),
        .lvl_high  (lpol_q),
        .ack       (ack_s),
        .nmi_en    (nmi_en_q)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xint_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (pin_sync[i]),
            .sense_lvl (sense_q[i]),
            .edge_rise (epol_q[i]),
            .lvl_high  (lpol_q[i]),
            .ack       (ack_s[i]),
            .pending   (pend_q[i])
        );
    end

    // Combine enabled pending lines; line 0 alone feeds the NMI path
    assign irq_o = |(pend_q & mask_q);
    assign nmi_o = nmi_en_q & pend_q[0];
endmodule

// File: rtl/xint_ctrl_chk.sv
// Property checker for xint_ctrl, attached by bind below.
// Observes bus ports and internal register state; drives nothing.
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 irq_o,
    input logic                 nmi_o,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] sense
);
    localparam logic [DATA_W-1:0] IMPL =
        (NUM_LINES >= DATA_W) ? '1 : DATA_W'((64'd1 << NUM_LINES) - 64'd1);

    logic wr_set, wr_clr, wr_ack0, rd_sense, rd_hole;
    assign wr_set   = bus_valid && bus_write && bus_addr == OFS_MASK_SET;
    assign wr_clr   = bus_valid && bus_write && bus_addr == OFS_MASK_CLR;
    assign wr_ack0  = bus_valid && bus_write && bus_addr == OFS_ACK && bus_wdata[0];
    assign rd_sense = bus_valid && !bus_write && bus_addr == OFS_SENSE_SEL;
    assign rd_hole  = bus_valid && !bus_write && bus_addr == 8'h20;

    // R2: set bits appear in the mask on the next cycle
    a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    // R2: cleared bits leave the mask on the next cycle
    a_r2_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R3: an edge-mode pending bit drops only after an acknowledge write
    a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pend[0]) && !$past(sense[0])) |-> $past(wr_ack0));

    // R6: with an empty mask the combined request stays low
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R7: the NMI output needs line 0 pending
    a_r7_nmi_src: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> pend[0]);

    // R8: unimplemented sense bits read zero
    a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sense |-> ((bus_rdata & ~IMPL) == '0));

    // R9: a hole in the map reads zero
    a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hole |-> (bus_rdata == '0));
endmodule

bind xint_ctrl xint_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .mask      (mask_q),
    .pend      (pend_q),
    .sense     (sense_q)
);

// File: tb/tb_xint_ctrl.sv
// Directed bench for xint_ctrl: one task per scenario.
module tb_xint_ctrl;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] ext_pin = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xint_ctrl #(.NUM_LINES(N)) dut (
        .clk (clk), .rst_n (rst_n), .ext_pin (ext_pin),
        .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq_o (irq_o), .nmi_o (nmi_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        foreach (dut.u_regs.mask[i]) ; // no-op, keeps loop style local
        for (int a = 8; a <= 36; a += 4) begin
            rd(8'(a), d);
            check("R1 reset word", d, 32'h0);
        end
        check("R1 irq low", {31'b0, irq_o}, 32'h0);
        check("R1 nmi low", {31'b0, nmi_o}, 32'h0);
    endtask

    task automatic t_discover();
        logic [31:0] d;
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d);
        check("R8 line discovery", d, 32'h0000_00FF);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h0C, d);
        check("R4 ack all", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(8'h00, 32'h0000_00A5);
        rd(8'h08, d);
        check("R2 mask set", d, 32'h0000_00A5);
        wr(8'h00, 32'h0000_0000);
        wr(8'h04, 32'h0000_0021);
        rd(8'h08, d);
        check("R2 mask clear", d, 32'h0000_0084);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d);
        check("R9 read-only mask write", d, 32'h0000_0084);
        wr(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(8'h18, 32'h0000_0005);          // lines 0 and 2 rising, others falling
        @(negedge clk); ext_pin[2] = 1'b1;
        settle();
        rd(8'h0C, d);
        check("R3 rising edge latched", d, 32'h0000_0004);
        wr(8'h10, 32'h0000_0004);
        settle();
        rd(8'h0C, d);
        check("R3 no re-trigger while high", d, 32'h0);
        @(negedge clk); ext_pin[3] = 1'b1;
        settle();
        rd(8'h0C, d);
        check("R3 falling line ignores rise", d, 32'h0);
        @(negedge clk); ext_pin[3] = 1'b0;
        settle();
        rd(8'h0C, d);
        check("R3 falling edge latched", d, 32'h0000_0008);
        wr(8'h0C, 32'h0);
        rd(8'h0C, d);
        check("R9 read-only pending write", d, 32'h0000_0008);
        wr(8'h10, 32'h0000_0001);
        rd(8'h0C, d);
        check("R4 zero ack bit keeps pending", d, 32'h0000_0008);
        wr(8'h10, 32'h0000_0008);
        rd(8'h0C, d);
        check("R4 ack clears", d, 32'h0);
        @(negedge clk); ext_pin[2] = 1'b0;
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(8'h1C, 32'h0000_0002);
        wr(8'h14, 32'h0000_0002);          // line 1 level, active high
        @(negedge clk); ext_pin[1] = 1'b1;
        settle();
        wr(8'h10, 32'h0000_0002);
        rd(8'h0C, d);
        check("R5 ack ignored while active", d, 32'h0000_0002);
        @(negedge clk); ext_pin[1] = 1'b0;
        settle();
        rd(8'h0C, d);
        check("R5 pending held after release", d, 32'h0000_0002);
        wr(8'h10, 32'h0000_0002);
        rd(8'h0C, d);
        check("R5 ack after release", d, 32'h0);
        wr(8'h14, 32'h0);
    endtask

    task automatic t_outputs();
        @(negedge clk); ext_pin[0] = 1'b1;  // line 0 rising
        settle();
        check("R6 pending but masked", {31'b0, irq_o}, 32'h0);
        check("R7 nmi disabled", {31'b0, nmi_o}, 32'h0);
        wr(8'h24, 32'h1);
        check("R7 nmi ignores mask", {31'b0, nmi_o}, 32'h1);
        wr(8'h00, 32'h1);
        check("R6 enabled pending raises irq", {31'b0, irq_o}, 32'h1);
        wr(8'h04, 32'h1);
        check("R6 mask clear drops irq", {31'b0, irq_o}, 32'h0);
        wr(8'h24, 32'h0);
        check("R7 nmi disable", {31'b0, nmi_o}, 32'h0);
    endtask

    task automatic t_holes();
        logic [31:0] d;
        rd(8'h20, d);
        check("R9 hole reads zero", d, 32'h0);
        wr(8'h00, 32'h1);
        rd(8'h00, d);
        check("R9 set word reads zero", d, 32'h0);
        rd(8'h10, d);
        check("R9 ack word reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_discover();
        t_mask();
        t_edges();
        t_level();
        t_outputs();
        t_holes();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule